// File: doc/BRIEF.md
# Dual-Precision Signed Array Multiplier

This block multiplies two two's-complement operands in a regular array of AND/full-adder cells. The sign bits are handled by the Baugh-Wooley method: partial-product bits that pair one sign bit with one magnitude bit enter the array complemented. Two constant ones added in the final stage correct the sum. No operand is sign-extended and nothing is subtracted. A select input picks the precision. In full precision the two 16-bit operands give a 32-bit signed product. In half precision only the low 8 bits of each operand are used and a 16-bit signed product results.

In half precision the array is reconfigured and not duplicated. The upper operand bits that enter the array are forced to zero, so the rows and columns outside the 8x8 corner stay quiet. The sign-handling complement moves to the 8-bit sign position. The full-width correction adder is held at zero. A row of output multiplexers then drives bits 31..16 with the sign of the 16-bit result. The low product bits come straight from the array and the small correction adder. The array is combinational. An output register, present by default, adds one cycle of latency.

Top module: `bw_dual_mult`

## Requirements
- R1: With `half_mode` = 0, `product` equals the signed product of `op_a` and `op_b`, both read as 16-bit two's-complement values, as a 32-bit two's-complement result.
- R2: With `half_mode` = 1, `product[15:0]` equals the signed product of `op_a[7:0]` and `op_b[7:0]`, both read as 8-bit two's-complement values.
- R3: With `half_mode` = 1, every bit of `product[31:16]` equals `product[15]`.
- R4: With `half_mode` = 1, the values of `op_a[15:8]` and `op_b[15:8]` do not change `product`.
- R5: The most negative operand times itself gives 0x4000_0000 in full precision (0x8000 times 0x8000) and 0x0000_4000 in half precision (0x80 times 0x80).
- R6: With the output register enabled (the default), `product` shows the result for the operands and mode sampled at a rising clock edge, and it holds that value until the next rising edge.
- R7: A rising clock edge with `rst_n` low clears `product` to zero. Reset is synchronous and active low.
- R8: A change of `half_mode` takes effect on the same edge as the operands sampled with it. Alternating modes on consecutive cycles gives the correct product for each cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| op_a | input | 16 | Multiplicand, two's complement; only bits 7..0 are used in half precision |
| op_b | input | 16 | Multiplier, two's complement; only bits 7..0 are used in half precision |
| half_mode | input | 1 | 0 selects 16x16 precision, 1 selects 8x8 precision |
| product | output | 32 | Signed product; in half precision a 16-bit result sign-extended to 32 bits |

## Verification
The assertions assume that the operands and `half_mode` are stable, known values at each rising edge. They compare the registered product against a behavioural signed multiply of the operands the checker captured at that edge. The bench meets this by changing inputs only on falling edges and never driving X. In half precision it fills the upper operand bits with random values, so the assertions and the bench both see that those bits are ignored. The half-precision space is covered exhaustively. Full precision is covered by every pairing of a corner-value set and by a long random sweep.

// File: rtl/bw_pkg.sv
// Package of shared types and elaboration-time helpers for the dual-precision
// Baugh-Wooley multiplier. Assumes operand indices count from zero at the LSB.
package bw_pkg;

    // Precision selected for the array.
    typedef enum logic {
        PREC_FULL = 1'b0,
        PREC_HALF = 1'b1
    } prec_e;

    // True when the partial product of a[row] and b[col] must enter the array
    // complemented for an operand width whose sign bit sits at index sgn.
    function automatic logic inv_term(input int row, input int col, input int sgn);
        return (row <= sgn) && (col <= sgn) && ((row == sgn) != (col == sgn));
    endfunction

endpackage

// File: rtl/bw_cell.sv
// One array cell: an AND gate forms a partial-product bit, optionally
// complemented for sign handling, and a full adder adds it to the incoming
// sum and carry. Purely combinational.
module bw_cell (
    input  logic a_bit,
    input  logic b_bit,
    input  logic flip,
    input  logic sum_in,
    input  logic carry_in,
    output logic sum_out,
    output logic carry_out
);
    logic pp;

    // Partial-product bit with Baugh-Wooley complement.
    assign pp        = (a_bit & b_bit) ^ flip;
    // Full-adder sum.
    assign sum_out   = pp ^ sum_in ^ carry_in;
    // Full-adder majority carry.
    assign carry_out = (pp & sum_in) | (pp & carry_in) | (sum_in & carry_in);

endmodule

// File: rtl/bw_array.sv
// Regular W x W array of bw_cell. Row j adds the partial products of b[j],
// shifted by j, into the running sum with a ripple carry along the row. The
// bit leaving the bottom of each row is product bit j. The complement pattern
// follows the selected precision: sign index W-1 in full mode, H-1 in half
// mode. The raw sum still lacks the Baugh-Wooley bias constants. The array
// assumes the caller zeroes operand bits above H-1 in half mode.
module bw_array #(
    parameter int W = 16,
    parameter int H = W / 2
) (
    input  logic [W-1:0]      a_in,
    input  logic [W-1:0]      b_in,
    input  bw_pkg::prec_e     prec,
    output logic [2*W-1:0]    raw
);
    import bw_pkg::*;

    logic [W-1:0] up [W];   // row sum bits
    logic [W-1:0] cy [W];   // row carry bits

    for (genvar j = 0; j < W; j++) begin : g_row
        for (genvar i = 0; i < W; i++) begin : g_col
            localparam logic INV_F = inv_term(i, j, W - 1);
            localparam logic INV_H = inv_term(i, j, H - 1);
            logic flip_c;
            logic s_in;
            logic c_in;

            // Complement select for this cell by precision.
            assign flip_c = (prec == PREC_HALF) ? INV_H : INV_F;

            // Sum input from the row above, shifted by one column.
            if (j == 0) begin : g_s0
                assign s_in = 1'b0;
            end else if (i == W - 1) begin : g_stop
                assign s_in = cy[j-1][W-1];
            end else begin : g_smid
                assign s_in = up[j-1][i+1];
            end

            // Ripple carry along the row.
            if (i == 0) begin : g_c0
                assign c_in = 1'b0;
            end else begin : g_cmid
                assign c_in = cy[j][i-1];
            end

            bw_cell u_cell (
                .a_bit    (a_in[i]),
                .b_bit    (b_in[j]),
                .flip     (flip_c),
                .sum_in   (s_in),
                .carry_in (c_in),
                .sum_out  (up[j][i]),
                .carry_out(cy[j][i])
            );
        end

        // Lowest bit of each row settles as a product bit.
        assign raw[j] = up[j][0];
    end

    // Top half from the last row and its carry-out.
    assign raw[2*W-1:W] = {cy[W-1][W-1], up[W-1][W-1:1]};

endmodule

// File: rtl/bw_finish.sv
// Final stage: adds the Baugh-Wooley bias ones (columns n and 2n-1) to the raw
// array sum and selects the output. In half mode only the low 2H bits go
// through a short bias adder, the full-width adder sees zeros, and the output
// multiplexers sign-extend the 2H-bit result. Assumes 2*H <= W.
module bw_finish #(
    parameter int W = 16,
    parameter int H = W / 2
) (
    input  logic [2*W-1:0]    raw,
    input  bw_pkg::prec_e     prec,
    output logic [2*W-1:0]    prod
);
    import bw_pkg::*;

    localparam int PW = 2 * W;
    localparam int PH = 2 * H;
    localparam logic [PW-1:0] ONE_F  = {{(PW-1){1'b0}}, 1'b1};
    localparam logic [PH-1:0] ONE_H  = {{(PH-1){1'b0}}, 1'b1};
    localparam logic [PW-1:0] BIAS_F = (ONE_F << W) | (ONE_F << (PW - 1));
    localparam logic [PH-1:0] BIAS_H = (ONE_H << H) | (ONE_H << (PH - 1));

    logic [PW-1:0] full_in;
    logic [PW-1:0] full_sum;
    logic [PH-1:0] half_sum;

    // Hold the wide adder quiet in half precision.
    assign full_in  = (prec == PREC_FULL) ? raw : '0;
    // Full-precision bias correction.
    assign full_sum = full_in + BIAS_F;
    // Half-precision bias correction on the low columns only.
    assign half_sum = raw[PH-1:0] + BIAS_H;

    // Output multiplexers: sign-extend the short result or pass the wide one.
    always_comb begin
        if (prec == PREC_HALF) begin
            prod = {{(PW-PH){half_sum[PH-1]}}, half_sum};
        end else begin
            prod = full_sum;
        end
    end

endmodule

// File: rtl/bw_dual_mult.sv
// Top of the dual-precision signed multiplier. Gates the operands to the
// selected precision, runs the Baugh-Wooley array and the bias/output stage,
// and optionally registers the product (synchronous active-low reset).
// Assumes H <= W/2 and operands presented as two's complement.
module bw_dual_mult #(
    parameter int W       = 16,
    parameter int H       = W / 2,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    input  logic             half_mode,
    output logic [2*W-1:0]   product
);
    import bw_pkg::*;

    prec_e          prec;
    logic [W-1:0]   a_arr;
    logic [W-1:0]   b_arr;
    logic [2*W-1:0] raw_sum;
    logic [2*W-1:0] prod_c;

    // Decode the precision select.
    assign prec  = half_mode ? PREC_HALF : PREC_FULL;
    // Force unused upper operand bits to zero in half precision.
    assign a_arr = (prec == PREC_HALF) ? {{(W-H){1'b0}}, op_a[H-1:0]} : op_a;
    assign b_arr = (prec == PREC_HALF) ? {{(W-H){1'b0}}, op_b[H-1:0]} : op_b;

    bw_array #(.W(W), .H(H)) u_array (
        .a_in (a_arr),
        .b_in (b_arr),
        .prec (prec),
        .raw  (raw_sum)
    );

    bw_finish #(.W(W), .H(H)) u_finish (
        .raw  (raw_sum),
        .prec (prec),
        .prod (prod_c)
    );

    if (OUT_REG) begin : g_reg
        // Output register with synchronous active-low reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                product <= '0;
            end else begin
                product <= prod_c;
            end
        end
    end else begin : g_comb
        assign product = prod_c;
    end

endmodule

// File: rtl/bw_dual_mult_chk.sv
// Assertion checker for bw_dual_mult, attached by bind. Captures the operands
// and mode alongside the output register (or uses them directly when the
// output is combinational) and compares the product with behavioural signed
// multiplies. Assumes inputs are known and stable at each rising edge.
module bw_dual_mult_chk #(
    parameter int W       = 16,
    parameter int H       = W / 2,
    parameter bit OUT_REG = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [W-1:0]     op_a,
    input logic [W-1:0]     op_b,
    input logic             half_mode,
    input logic [2*W-1:0]   product
);
    localparam int HI_LIM = 2 ** (2 * H - 2);
    localparam int LO_LIM = -(2 ** (2 * H - 2)) + 2 ** (H - 1);
    localparam logic [W-1:0]   MIN_F = {1'b1, {(W-1){1'b0}}};
    localparam logic [2*W-1:0] SQ_F  = {2'b01, {(2*W-2){1'b0}}};

    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    logic         h_q;
    logic         vld;

    if (OUT_REG) begin : g_cap
        // Capture what the output register sampled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_q <= '0;
                b_q <= '0;
                h_q <= 1'b0;
                vld <= 1'b0;
            end else begin
                a_q <= op_a;
                b_q <= op_b;
                h_q <= half_mode;
                vld <= 1'b1;
            end
        end
    end else begin : g_dir
        assign a_q = op_a;
        assign b_q = op_b;
        assign h_q = half_mode;
        assign vld = 1'b1;
    end

    logic signed [2*W-1:0] full_exp;
    logic signed [2*H-1:0] half_exp;
    assign full_exp = $signed(a_q) * $signed(b_q);
    assign half_exp = $signed(a_q[H-1:0]) * $signed(b_q[H-1:0]);

    // R1: full precision equals the behavioural signed product.
    p_full_prod_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !h_q) |-> (product == full_exp));

    // R2 and R4: low half equals the short product of the low operand bits only.
    p_half_prod_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && h_q) |-> (product[2*H-1:0] == half_exp));

    // R3: upper bits copy the short result's sign.
    p_half_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && h_q) |-> (product[2*W-1:2*H] == {(2*W-2*H){product[2*H-1]}}));

    // R2: half-precision result stays within the signed short range.
    p_half_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && h_q) |-> (($signed(product) <= HI_LIM) && ($signed(product) >= LO_LIM)));

    // R5: most negative value squared in full precision.
    p_min_sq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !h_q && a_q == MIN_F && b_q == MIN_F) |-> (product == SQ_F));

endmodule

bind bw_dual_mult bw_dual_mult_chk #(.W(W), .H(H), .OUT_REG(OUT_REG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_a      (op_a),
    .op_b      (op_b),
    .half_mode (half_mode),
    .product   (product)
);

// File: tb/tb_bw_dual_mult.sv
// Self-checking bench: reset, corner pairs, random full-precision sweep,
// exhaustive half-precision sweep with random upper bits, latency and mode
// switching. Inputs change on falling edges; outputs sampled on falling edges.
module tb_bw_dual_mult;
    logic        clk;
    logic        rst_n;
    logic [15:0] op_a;
    logic [15:0] op_b;
    logic        half_mode;
    logic [31:0] product;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    bw_dual_mult dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_a      (op_a),
        .op_b      (op_b),
        .half_mode (half_mode),
        .product   (product)
    );

    // 50 MHz clock.
    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Expected product computed arithmetically from the requirements.
    function automatic logic [31:0] model(input logic [15:0] a, input logic [15:0] b,
                                         input logic h);
        int p;
        if (h) p = int'($signed(a[7:0])) * int'($signed(b[7:0]));
        else   p = int'($signed(a)) * int'($signed(b));
        return p;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Apply at a falling edge, then check one clock later (R6 latency).
    task automatic run(input logic [15:0] a, input logic [15:0] b, input logic h,
                       input string tag);
        op_a = a; op_b = b; half_mode = h;
        @(negedge clk);
        check(tag, product, model(a, b, h));
    endtask

    logic [15:0] corners [16] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h0002,
                                  16'h7FFF, 16'h8000, 16'h8001, 16'h5555,
                                  16'hAAAA, 16'h00FF, 16'hFF00, 16'h0100,
                                  16'h1234, 16'hFFFE, 16'h4000, 16'hC000};

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold;
        rst_n = 1'b0; op_a = 16'h7FFF; op_b = 16'h7FFF; half_mode = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 reset state", product, 32'h0);
        rst_n = 1'b1;

        // R5 corners in both precisions.
        run(16'h8000, 16'h8000, 1'b0, "R5 full min squared");
        check("R5 full min value", product, 32'h4000_0000);
        run(16'h3C80, 16'hA580, 1'b1, "R5 half min squared");
        check("R5 half min value", product, 32'h0000_4000);

        // R1 all corner pairs.
        foreach (corners[x]) begin
            foreach (corners[y]) begin
                run(corners[x], corners[y], 1'b0, "R1 corner pair");
            end
        end

        // R1 random full-precision sweep.
        for (int k = 0; k < 30000; k++) begin
            run(16'($urandom), 16'($urandom), 1'b0, "R1 random");
        end

        // R2 R3 exhaustive half precision with random upper bits (R4).
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                run({8'($urandom), 8'(x)}, {8'($urandom), 8'(y)}, 1'b1, "R2 R3 half sweep");
            end
        end

        // R4 upper bits have no effect: same low bits, different upper bits.
        for (int k = 0; k < 64; k++) begin
            logic [7:0] la;
            logic [7:0] lb;
            la = 8'($urandom); lb = 8'($urandom);
            run({8'h00, la}, {8'h00, lb}, 1'b1, "R4 zero upper");
            hold = product;
            op_a = {8'($urandom) | 8'h01, la}; op_b = {8'hFF, lb};
            @(negedge clk);
            check("R4 upper ignored", product, hold);
        end

        // R6 output holds until the next rising edge.
        run(16'h1234, 16'h0567, 1'b0, "R6 first");
        hold = product;
        op_a = 16'hFEDC; op_b = 16'h8001; half_mode = 1'b1;
        #1;
        check("R6 hold before edge", product, hold);
        @(negedge clk);
        check("R6 after edge", product, model(16'hFEDC, 16'h8001, 1'b1));

        // R8 alternating precision on consecutive cycles.
        for (int k = 0; k < 200; k++) begin
            logic [15:0] a;
            logic [15:0] b;
            a = 16'($urandom); b = 16'($urandom);
            run(a, b, 1'(k % 2), "R8 mode switch");
        end

        // R7 mid-run reset clears the output.
        op_a = 16'h8000; op_b = 16'h7FFF; half_mode = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R7 mid-run reset", product, 32'h0);
        rst_n = 1'b1;
        run(16'h8000, 16'h7FFF, 1'b0, "R7 after release");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule